// File: doc/BRIEF.md
# Bidirectional GPIO Port with Pull-up Control

This block is a parameterised bidirectional I/O port, eight pins wide by default, for a pad ring. Each pin has a direction bit, a data bit and a synchronised read of the pad. Software reaches them through a small write port with three addressable registers and one registered read port. The direction bit turns the pad driver on or off. The data bit sets the driven level when the pin is an output and enables a weak pull-up when it is an input. The pad level is sampled through a two-flop synchroniser before it can be read.

A write carries an operation code. The code selects a full-register write, or a set or clear of the single bit named by a bit index. Because of this, one pin can be changed without a read-modify-write sequence and without disturbing the other pins. A write aimed at the pin-read register toggles data bits instead of storing anything there. A global pull-up disable input turns every pull-up off, whatever the register contents.

Top module: `gpio_port_pu`

## Requirements
- R1: While `rst` is high at a clock edge, the direction and data registers clear to zero. After that edge every pin is an input with no pull-up and `pad_out` is zero, and a read of either register returns zero.
- R2: Register select codes on `bus_sel` are 0 for direction, 1 for data, 2 for pin read and 3 for none. An operation `bus_op`=0 with `bus_wr` high replaces the whole selected register (direction or data) with `bus_wdata` at the clock edge.
- R3: `pad_oe[i]` equals direction bit i, so a 1 makes pin i an output and a 0 makes it an input.
- R4: `pad_out[i]` is data bit i when pin i is an output and 0 when it is an input.
- R5: `pad_pu[i]` is 1 exactly when pin i is an input, data bit i is 1 and `pu_off` is low. Setting the pin to output or clearing its data bit removes the pull-up.
- R6: While `pu_off` is high, every bit of `pad_pu` is 0.
- R7: Operation `bus_op`=1 on the direction or data register sets bit `bus_idx` and leaves every other bit unchanged.
- R8: Operation `bus_op`=2 on the direction or data register clears bit `bus_idx` and leaves every other bit unchanged.
- R9: The pin-read register holds the value `pad_in` had two clock edges earlier. `rd_data` with `rd_sel`=2 therefore shows a pad change after the third edge, and not after the second.
- R10: On the pin-read select, operation 0 XORs `bus_wdata` into the data register. Operation 1 toggles data bit `bus_idx`. Operation 2 changes nothing.
- R11: Writes with `bus_sel`=3, and writes with `bus_op`=3, change no register. Reads with `rd_sel`=3 return zero.
- R12: `rd_data` is a register updated at every clock edge. After an edge it shows the contents, as they stood before that edge, of the register named by `rd_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_sel | input | 2 | Write register select: 0 direction, 1 data, 2 pin read, 3 none |
| bus_op | input | 2 | Write operation: 0 full, 1 set bit, 2 clear bit, 3 none |
| bus_idx | input | $clog2(W) | Bit index for set and clear |
| bus_wdata | input | W | Full-write data |
| rd_sel | input | 2 | Read register select |
| rd_data | output | W | Registered read data |
| pu_off | input | 1 | Global pull-up disable |
| pad_in | input | W | Pad levels (asynchronous) |
| pad_oe | output | W | Pad driver enables |
| pad_out | output | W | Pad drive levels |
| pad_pu | output | W | Pad pull-up enables |

## Verification
The pad controls are swept over every data value under four direction patterns: all inputs, all outputs, and two mixed ones. This shows that the output-value path and the pull-up path are each gated by the right polarity of the direction bit. The same sweep with `pu_off` high separates the global override from the per-pin enable. Every bit index is used for set, clear and toggle, from a start value with both ones and zeros, so a wrong index or a disturbed neighbour bit shows up. All 256 pad values are stepped through the synchroniser and sampled after both the second and the third edge, which pins the latency to exactly two stages.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [1:0] {
    SEL_DIR  = 2'd0,
    SEL_DATA = 2'd1,
    SEL_PIN  = 2'd2,
    SEL_NONE = 2'd3
  } gpio_sel_e;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_SET   = 2'd1,
    OP_CLR   = 2'd2,
    OP_NOP   = 2'd3
  } gpio_op_e;
endpackage

// File: rtl/gpio_bitops.sv
// Next-value logic for one control register: full write, single-bit set or clear,
// or (TOGGLE variant) XOR-style update used by writes to the pin-read address.
module gpio_bitops #(
  parameter int W      = 8,
  parameter bit TOGGLE = 1'b0,
  localparam int IW    = (W > 1) ? $clog2(W) : 1
) (
  input  logic              en,
  input  gpio_pkg::gpio_op_e op,
  input  logic [IW-1:0]     idx,
  input  logic [W-1:0]      wdata,
  input  logic [W-1:0]      cur,
  output logic              hit,
  output logic [W-1:0]      nxt
);
  import gpio_pkg::*;

  logic [W-1:0] onehot;
  assign onehot = W'(1) << idx;

  generate
    if (TOGGLE) begin : g_toggle
      always_comb begin
        nxt = cur;
        hit = 1'b0;
        if (en) begin
          unique case (op)
            OP_WRITE: begin nxt = cur ^ wdata;  hit = 1'b1; end
            OP_SET:   begin nxt = cur ^ onehot; hit = 1'b1; end
            default:  begin nxt = cur;          hit = 1'b0; end
          endcase
        end
      end
    end else begin : g_plain
      always_comb begin
        nxt = cur;
        hit = 1'b0;
        if (en) begin
          unique case (op)
            OP_WRITE: begin nxt = wdata;         hit = 1'b1; end
            OP_SET:   begin nxt = cur | onehot;  hit = 1'b1; end
            OP_CLR:   begin nxt = cur & ~onehot; hit = 1'b1; end
            default:  begin nxt = cur;           hit = 1'b0; end
          endcase
        end
      end
    end
  endgenerate
endmodule

// File: rtl/gpio_sync.sv
// Multi-stage synchroniser for asynchronous pad levels. Flops carry no reset
// so they track the pad from the first clock onward.
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) chain[0] <= din;

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) chain[s] <= chain[s-1];
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/gpio_pad_ctl.sv
// Per-pin pad control decode from the direction and data registers.
module gpio_pad_ctl #(
  parameter int W = 8
) (
  input  logic [W-1:0] dir,
  input  logic [W-1:0] data,
  input  logic         pu_off,
  output logic [W-1:0] oe,
  output logic [W-1:0] drive,
  output logic [W-1:0] pu
);
  generate
    for (genvar i = 0; i < W; i++) begin : g_pin
      assign oe[i]    = dir[i];
      assign drive[i] = dir[i] & data[i];
      assign pu[i]    = ~dir[i] & data[i] & ~pu_off;
    end
  endgenerate
endmodule

// File: rtl/gpio_port_pu.sv
module gpio_port_pu #(
  parameter int W        = 8,
  parameter int SYNC_LEN = 2,
  localparam int IW      = (W > 1) ? $clog2(W) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic [1:0]    bus_sel,
  input  logic [1:0]    bus_op,
  input  logic [IW-1:0] bus_idx,
  input  logic [W-1:0]  bus_wdata,
  input  logic [1:0]    rd_sel,
  output logic [W-1:0]  rd_data,
  input  logic          pu_off,
  input  logic [W-1:0]  pad_in,
  output logic [W-1:0]  pad_oe,
  output logic [W-1:0]  pad_out,
  output logic [W-1:0]  pad_pu
);
  import gpio_pkg::*;

  gpio_sel_e sel;
  gpio_op_e  op;
  assign sel = gpio_sel_e'(bus_sel);
  assign op  = gpio_op_e'(bus_op);

  logic [W-1:0] dir_q, data_q, pin_q;
  logic [W-1:0] dir_nxt, data_nxt, tog_nxt;
  logic         dir_hit, data_hit, tog_hit;

  gpio_bitops #(.W(W), .TOGGLE(1'b0)) i_dir_ops (
    .en(bus_wr && sel == SEL_DIR), .op(op), .idx(bus_idx), .wdata(bus_wdata),
    .cur(dir_q), .hit(dir_hit), .nxt(dir_nxt)
  );

  gpio_bitops #(.W(W), .TOGGLE(1'b0)) i_data_ops (
    .en(bus_wr && sel == SEL_DATA), .op(op), .idx(bus_idx), .wdata(bus_wdata),
    .cur(data_q), .hit(data_hit), .nxt(data_nxt)
  );

  gpio_bitops #(.W(W), .TOGGLE(1'b1)) i_tog_ops (
    .en(bus_wr && sel == SEL_PIN), .op(op), .idx(bus_idx), .wdata(bus_wdata),
    .cur(data_q), .hit(tog_hit), .nxt(tog_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q  <= '0;
      data_q <= '0;
    end else begin
      if (dir_hit)       dir_q  <= dir_nxt;
      if (data_hit)      data_q <= data_nxt;
      else if (tog_hit)  data_q <= tog_nxt;
    end
  end

  gpio_sync #(.W(W), .STAGES(SYNC_LEN)) i_sync (
    .clk(clk), .din(pad_in), .dout(pin_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      unique case (gpio_sel_e'(rd_sel))
        SEL_DIR:  rd_data <= dir_q;
        SEL_DATA: rd_data <= data_q;
        SEL_PIN:  rd_data <= pin_q;
        default:  rd_data <= '0;
      endcase
    end
  end

  gpio_pad_ctl #(.W(W)) i_pads (
    .dir(dir_q), .data(data_q), .pu_off(pu_off),
    .oe(pad_oe), .drive(pad_out), .pu(pad_pu)
  );
endmodule

// File: rtl/gpio_port_pu_chk.sv
module gpio_port_pu_chk #(
  parameter int W  = 8,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_wr,
  input logic [1:0]    bus_sel,
  input logic [1:0]    bus_op,
  input logic [IW-1:0] bus_idx,
  input logic [W-1:0]  bus_wdata,
  input logic          pu_off,
  input logic [W-1:0]  pad_in,
  input logic [W-1:0]  pad_oe,
  input logic [W-1:0]  pad_pu,
  input logic [W-1:0]  dir_q,
  input logic [W-1:0]  data_q,
  input logic [W-1:0]  pin_q
);
  logic [1:0] age = 2'd0;
  always_ff @(posedge clk) if (age != 2'd3) age <= age + 2'd1;

  // R5
  pu_not_driven_chk: assert property (@(posedge clk) disable iff (rst)
    (pad_pu & pad_oe) == '0);

  // R6
  pu_global_off_chk: assert property (@(posedge clk) disable iff (rst)
    pu_off |-> pad_pu == '0);

  // R7
  data_set_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_sel == 2'd1 && bus_op == 2'd1) |=>
      data_q == ($past(data_q) | (W'(1) << $past(bus_idx))));

  // R8
  dir_clr_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_sel == 2'd0 && bus_op == 2'd2) |=>
      dir_q == ($past(dir_q) & ~(W'(1) << $past(bus_idx))));

  // R9
  sync_two_stage_chk: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3) |-> pin_q == $past(pad_in, 2));

  // R10
  pin_write_xor_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_sel == 2'd2 && bus_op == 2'd0) |=>
      data_q == ($past(data_q) ^ $past(bus_wdata)));

  // R11
  nop_keeps_regs_chk: assert property (@(posedge clk) disable iff (rst)
    (!bus_wr || bus_sel == 2'd3 || bus_op == 2'd3) |=>
      ($stable(data_q) && $stable(dir_q)));
endmodule

bind gpio_port_pu gpio_port_pu_chk #(.W(W)) i_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_sel(bus_sel), .bus_op(bus_op),
  .bus_idx(bus_idx), .bus_wdata(bus_wdata), .pu_off(pu_off), .pad_in(pad_in),
  .pad_oe(pad_oe), .pad_pu(pad_pu), .dir_q(dir_q), .data_q(data_q), .pin_q(pin_q)
);

// File: tb/test_gpio_port_pu.sv
`timescale 1ns/1ps
module test_gpio_port_pu;
  localparam int W  = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr = 1'b0;
  logic [1:0]    bus_sel = 2'd0;
  logic [1:0]    bus_op = 2'd3;
  logic [IW-1:0] bus_idx = '0;
  logic [W-1:0]  bus_wdata = '0;
  logic [1:0]    rd_sel = 2'd0;
  logic [W-1:0]  rd_data;
  logic          pu_off = 1'b0;
  logic [W-1:0]  pad_in = '0;
  logic [W-1:0]  pad_oe, pad_out, pad_pu;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gpio_port_pu #(.W(W)) i_gpio_port_pu (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_sel(bus_sel), .bus_op(bus_op),
    .bus_idx(bus_idx), .bus_wdata(bus_wdata), .rd_sel(rd_sel), .rd_data(rd_data),
    .pu_off(pu_off), .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out),
    .pad_pu(pad_pu)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a negedge; returns at the negedge after the write edge.
  task automatic wr(input logic [1:0] sel, input logic [1:0] op,
                    input logic [IW-1:0] idx, input logic [W-1:0] d);
    bus_wr = 1'b1; bus_sel = sel; bus_op = op; bus_idx = idx; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0; bus_op = 2'd3;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [W-1:0] v);
    rd_sel = sel;
    @(posedge clk); @(negedge clk);
    v = rd_data;
  endtask

  initial begin
    logic [W-1:0] v, m_dir, m_data, prev;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check("R1 oe", pad_oe, '0);
    check("R1 pu", pad_pu, '0);
    check("R1 out", pad_out, '0);
    rd(2'd0, v); check("R1 dir read", v, '0);
    rd(2'd1, v); check("R1 data read", v, '0);

    // R2 R3 R4 R5 R6: sweep data under several direction patterns
    foreach (m_dir[k]) m_dir[k] = 1'b0;
    for (int p = 0; p < 4; p++) begin
      logic [W-1:0] dpat [4];
      dpat[0] = 8'h00; dpat[1] = 8'hFF; dpat[2] = 8'hA5; dpat[3] = 8'h3C;
      m_dir = dpat[p];
      wr(2'd0, 2'd0, '0, m_dir);
      for (int d = 0; d < 256; d++) begin
        m_data = W'(d);
        wr(2'd1, 2'd0, '0, m_data);
        check("R3 oe", pad_oe, m_dir);
        check("R4 out", pad_out, m_dir & m_data);
        check("R5 pu", pad_pu, ~m_dir & m_data);
        pu_off = 1'b1; #1;
        check("R6 pu off", pad_pu, '0);
        pu_off = 1'b0; #1;
      end
    end
    rd(2'd0, v); check("R2 dir read", v, m_dir);
    rd(2'd1, v); check("R12 data read", v, m_data);

    // R7 R8: set and clear on each bit index
    m_data = 8'h5A; wr(2'd1, 2'd0, '0, m_data);
    m_dir  = 8'hC3; wr(2'd0, 2'd0, '0, m_dir);
    for (int i = 0; i < W; i++) begin
      wr(2'd1, 2'd1, IW'(i), 8'h00); m_data = m_data | (W'(1) << i);
      rd(2'd1, v); check("R7 data set", v, m_data);
      wr(2'd0, 2'd2, IW'(i), 8'hFF); m_dir = m_dir & ~(W'(1) << i);
      rd(2'd0, v); check("R8 dir clr", v, m_dir);
      wr(2'd1, 2'd2, IW'(i), 8'hFF); m_data = m_data & ~(W'(1) << i);
      rd(2'd1, v); check("R8 data clr", v, m_data);
      wr(2'd0, 2'd1, IW'(i), 8'h00); m_dir = m_dir | (W'(1) << i);
      rd(2'd0, v); check("R7 dir set", v, m_dir);
    end

    // R10: toggle through pin-read address
    m_data = 8'h96; wr(2'd1, 2'd0, '0, m_data);
    wr(2'd2, 2'd0, '0, 8'h0F); m_data = m_data ^ 8'h0F;
    rd(2'd1, v); check("R10 xor write", v, m_data);
    for (int i = 0; i < W; i++) begin
      wr(2'd2, 2'd1, IW'(i), 8'h00); m_data = m_data ^ (W'(1) << i);
      rd(2'd1, v); check("R10 bit toggle", v, m_data);
      wr(2'd2, 2'd2, IW'(i), 8'hFF);
      rd(2'd1, v); check("R10 clr ignored", v, m_data);
    end

    // R11: ignored select and op
    wr(2'd3, 2'd0, '0, ~m_data);
    rd(2'd1, v); check("R11 sel3 data", v, m_data);
    rd(2'd0, v); check("R11 sel3 dir", v, m_dir);
    wr(2'd1, 2'd3, '0, ~m_data);
    rd(2'd1, v); check("R11 op3 data", v, m_data);
    rd(2'd3, v); check("R11 read sel3", v, '0);

    // R9 R12: synchroniser latency over all pad values
    rd_sel = 2'd2;
    prev = pad_in;
    repeat (3) @(negedge clk);
    for (int n = 1; n <= 256; n++) begin
      pad_in = W'(n * 37 + 5);
      @(negedge clk); @(negedge clk);
      check("R9 not yet", rd_data, prev);
      @(negedge clk);
      check("R9 pin read", rd_data, pad_in);
      prev = pad_in;
    end

    // R1: reset again clears registers
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    check("R1 re-reset oe", pad_oe, '0);
    rd(2'd1, v); check("R1 re-reset data", v, '0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule